// File: doc/BRIEF.md
# Configurable Compare-Node Median Network

This block evaluates a chain of 8-bit compare nodes over a window of pixel samples. Each node is described by a small gene that names two operand sources and a function: pass-through, minimum or maximum. An extra value picks which source drives the output. Loaded with enough nodes, the genome can implement an exact median. With fewer nodes it gives an approximate median that needs fewer operations. Nine window samples and thirty-eight nodes are the defaults. These are enough for an exact nine-sample median built from nineteen exchange pairs. The parameters also allow a 25-sample window with up to 220 nodes.

Windows enter with a valid strobe, and one window can be accepted every clock. The window and its reference median are registered. The whole node chain then settles within one cycle, and the result is registered on the following edge. When each result lands, an error accumulator adds the absolute difference between the network output and the reference. A search loop can therefore score a candidate genome over a stream of training windows. A clear strobe starts a new score. The accumulator is sized so that it cannot overflow over 100000 windows of 8-bit differences.

Top module: `cmpnet_median`

## Requirements
- R1: After reset, out_valid is 0, out_sample is 0 and err_sum is 0. Every node gene resets to sources 0 and 0 with function code 0, and the output select resets to 0, so the first window yields sample 0 of that window.
- R2: Node function codes are 2 bits wide. Code 0 passes the first operand, code 1 gives the smaller operand, code 2 gives the larger operand, and code 3 behaves like code 0.
- R3: Source indices share one space. Values 0 to NUM_IN-1 select window samples, where sample i sits at in_win bits [8i+7:8i]. Value NUM_IN+k selects node k. For node k, any source index of NUM_IN+k or above (itself, a later node, or out of range) reads as 0.
- R4: outsel_idx selects the output from the same index space, over all inputs and all nodes. Values of NUM_IN+NUM_NODES or above give an output of 0.
- R5: A window accepted with in_valid at clock edge n appears on out_sample with out_valid high after edge n+2. One window is accepted per cycle. out_valid is low in every other cycle, and out_sample then holds its last value.
- R6: At the edge where a result is registered, err_sum grows by |result - reference| for that window. Otherwise it is unchanged.
- R7: err_clr sets err_sum to 0 at the next edge. If a result lands at that same edge, err_sum becomes that result's difference alone.
- R8: A gene write with gene_slot of NUM_NODES or above changes no node, including the node whose index equals the slot modulo a power of two.
- R9: A 38-node genome of nineteen min/max exchange pairs produces the exact median of nine samples, ties included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gene_we | input | 1 | Write one node gene |
| gene_slot | input | 8 | Node index written |
| gene_src_a | input | 8 | First operand source index |
| gene_src_b | input | 8 | Second operand source index |
| gene_fn | input | 2 | Node function code |
| outsel_we | input | 1 | Write output select |
| outsel_idx | input | 8 | Source index driving the output |
| in_valid | input | 1 | Window present |
| in_win | input | NUM_IN*8 | Window samples, sample i at bits [8i+7:8i] |
| in_ref | input | 8 | Reference median for this window |
| err_clr | input | 1 | Restart the error sum |
| out_valid | output | 1 | Result registered this cycle |
| out_sample | output | 8 | Network output |
| err_sum | output | ACC_W | Accumulated absolute error |

## Verification
The clear strobe and the landing of a result can fall on the same edge. In that case the sum must restart from that window's difference, not from zero and not from the old total. The bench provokes this by raising err_clr exactly one cycle after a window's in_valid. It also raises a clear on an idle edge and among random back-to-back traffic. A scoreboard predicts the running sum from the requirement and compares it with err_sum each time a result is delivered.

// File: rtl/cmpnet_pkg.sv
package cmpnet_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 8;

    typedef logic [DATA_W-1:0] sample_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        OP_PASS  = 2'd0,
        OP_MIN   = 2'd1,
        OP_MAX   = 2'd2,
        OP_SPARE = 2'd3
    } op_e;

    typedef struct packed {
        idx_t src_a;
        idx_t src_b;
        op_e  op;
    } gene_t;

    function automatic sample_t apply_op(op_e op, sample_t a, sample_t b);
        case (op)
            OP_MIN:  return (a < b) ? a : b;
            OP_MAX:  return (a > b) ? a : b;
            default: return a;
        endcase
    endfunction

    function automatic sample_t abs_diff(sample_t a, sample_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/cmpnet_genome.sv
module cmpnet_genome
    import cmpnet_pkg::*;
#(
    parameter int NUM_NODES = 38
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     gene_we,
    input  idx_t                     gene_slot,
    input  gene_t                    gene_new,
    input  logic                     outsel_we,
    input  idx_t                     outsel_new,
    output gene_t [NUM_NODES-1:0]    genes,
    output idx_t                     out_sel
);

    gene_t [NUM_NODES-1:0] genes_q;
    idx_t                  sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            genes_q <= '0;
            sel_q   <= '0;
        end else begin
            for (int s = 0; s < NUM_NODES; s++) begin
                if (gene_we && gene_slot == IDX_W'(s)) begin
                    genes_q[s] <= gene_new;
                end
            end
            if (outsel_we) begin
                sel_q <= outsel_new;
            end
        end
    end

    assign genes   = genes_q;
    assign out_sel = sel_q;

endmodule

// File: rtl/cmpnet_node.sv
module cmpnet_node
    import cmpnet_pkg::*;
#(
    parameter int NUM_AVAIL = 9
) (
    input  sample_t [NUM_AVAIL-1:0] avail,
    input  gene_t                   gene,
    output sample_t                 y
);

    sample_t opa;
    sample_t opb;

    // Sources at or beyond NUM_AVAIL are not visible to this node and read as 0.
    always_comb begin
        opa = '0;
        opb = '0;
        for (int i = 0; i < NUM_AVAIL; i++) begin
            if (gene.src_a == IDX_W'(i)) opa = avail[i];
            if (gene.src_b == IDX_W'(i)) opb = avail[i];
        end
    end

    assign y = apply_op(gene.op, opa, opb);

endmodule

// File: rtl/cmpnet_network.sv
module cmpnet_network
    import cmpnet_pkg::*;
#(
    parameter int NUM_IN    = 9,
    parameter int NUM_NODES = 38,
    localparam int NUM_SRC  = NUM_IN + NUM_NODES,
    localparam int LAST     = NUM_NODES - 1
) (
    input  sample_t [NUM_IN-1:0]    win,
    input  gene_t   [NUM_NODES-1:0] genes,
    input  idx_t                    out_sel,
    output sample_t                 y
);

    // Each level extends the pool of visible values by one node output,
    // so node k can only see inputs and nodes 0..k-1.
    genvar k;
    generate
        for (k = 0; k < NUM_NODES; k++) begin : g_lvl
            sample_t [NUM_IN+k:0] pool;
            sample_t              node_y;
            if (k == 0) begin : g_first
                cmpnet_node #(.NUM_AVAIL(NUM_IN)) u_node (
                    .avail (win),
                    .gene  (genes[0]),
                    .y     (node_y)
                );
                assign pool = {node_y, win};
            end else begin : g_rest
                cmpnet_node #(.NUM_AVAIL(NUM_IN + k)) u_node (
                    .avail (g_lvl[k-1].pool),
                    .gene  (genes[k]),
                    .y     (node_y)
                );
                assign pool = {node_y, g_lvl[k-1].pool};
            end
        end
    endgenerate

    sample_t [NUM_SRC-1:0] all_src;
    assign all_src = g_lvl[LAST].pool;

    always_comb begin
        y = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (out_sel == IDX_W'(i)) y = all_src[i];
        end
    end

endmodule

// File: rtl/cmpnet_accum.sv
module cmpnet_accum
    import cmpnet_pkg::*;
#(
    parameter int ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add_en,
    input  sample_t          net_y,
    input  sample_t          tgt,
    output logic [ACC_W-1:0] sum
);

    logic [ACC_W-1:0] delta;
    logic [ACC_W-1:0] base;

    always_comb begin
        delta = add_en ? ACC_W'(abs_diff(net_y, tgt)) : '0;
        base  = clr ? '0 : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else begin
            sum <= base + delta;
        end
    end

endmodule

// File: rtl/cmpnet_median.sv
module cmpnet_median
    import cmpnet_pkg::*;
#(
    parameter int NUM_IN      = 9,
    parameter int NUM_NODES   = 38,
    parameter int MAX_VECTORS = 100000,
    localparam int ACC_W      = $clog2(MAX_VECTORS * ((1 << DATA_W) - 1) + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     gene_we,
    input  logic [IDX_W-1:0]         gene_slot,
    input  logic [IDX_W-1:0]         gene_src_a,
    input  logic [IDX_W-1:0]         gene_src_b,
    input  logic [1:0]               gene_fn,
    input  logic                     outsel_we,
    input  logic [IDX_W-1:0]         outsel_idx,
    input  logic                     in_valid,
    input  logic [NUM_IN*DATA_W-1:0] in_win,
    input  logic [DATA_W-1:0]        in_ref,
    input  logic                     err_clr,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_sample,
    output logic [ACC_W-1:0]         err_sum
);

    gene_t                 gene_new;
    gene_t [NUM_NODES-1:0] genes;
    idx_t                  out_sel;

    assign gene_new = '{src_a: gene_src_a, src_b: gene_src_b, op: op_e'(gene_fn)};

    cmpnet_genome #(.NUM_NODES(NUM_NODES)) u_genome (
        .clk        (clk),
        .rst        (rst),
        .gene_we    (gene_we),
        .gene_slot  (gene_slot),
        .gene_new   (gene_new),
        .outsel_we  (outsel_we),
        .outsel_new (outsel_idx),
        .genes      (genes),
        .out_sel    (out_sel)
    );

    // Stage 1: capture window and reference.
    logic                st_valid;
    sample_t [NUM_IN-1:0] st_win;
    sample_t              st_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid <= 1'b0;
            st_win   <= '0;
            st_ref   <= '0;
        end else begin
            st_valid <= in_valid;
            if (in_valid) begin
                st_win <= in_win;
                st_ref <= in_ref;
            end
        end
    end

    // Node chain settles combinationally from the staged window.
    sample_t net_y;

    cmpnet_network #(.NUM_IN(NUM_IN), .NUM_NODES(NUM_NODES)) u_net (
        .win     (st_win),
        .genes   (genes),
        .out_sel (out_sel),
        .y       (net_y)
    );

    // Stage 2: register result and score it.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= st_valid;
            if (st_valid) begin
                out_sample <= net_y;
            end
        end
    end

    cmpnet_accum #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (err_clr),
        .add_en (st_valid),
        .net_y  (net_y),
        .tgt    (st_ref),
        .sum    (err_sum)
    );

endmodule

// File: rtl/cmpnet_median_chk.sv
module cmpnet_median_chk #(
    parameter int ACC_W = 25
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             err_clr,
    input logic             out_valid,
    input logic [7:0]       out_sample,
    input logic [ACC_W-1:0] err_sum
);

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == 8'd0 && err_sum == '0)); // R1

    AST_PIPE_DEPTH: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid); // R5

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample)); // R5

    AST_SUM_STILL: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> (out_valid || $stable(err_sum))); // R6

    AST_SUM_GROWS: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> (err_sum >= $past(err_sum))); // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (out_valid || err_sum == '0)); // R7

    AST_CLEAR_BOUND: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (err_sum <= ACC_W'(255))); // R7

endmodule

bind cmpnet_median cmpnet_median_chk #(.ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .err_clr    (err_clr),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .err_sum    (err_sum)
);

// File: tb/sim_cmpnet_median.sv
`timescale 1ns/1ps
module sim_cmpnet_median;

    localparam int NI = 9;
    localparam int NN = 38;
    localparam int NS = NI + NN;
    localparam int AW = 25;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            gene_we = 1'b0;
    logic [7:0]      gene_slot = '0;
    logic [7:0]      gene_src_a = '0;
    logic [7:0]      gene_src_b = '0;
    logic [1:0]      gene_fn = '0;
    logic            outsel_we = 1'b0;
    logic [7:0]      outsel_idx = '0;
    logic            in_valid = 1'b0;
    logic [NI*8-1:0] in_win = '0;
    logic [7:0]      in_ref = '0;
    logic            err_clr = 1'b0;
    logic            out_valid;
    logic [7:0]      out_sample;
    logic [AW-1:0]   err_sum;

    always #4 clk = ~clk;

    cmpnet_median u0 (
        .clk        (clk),
        .rst        (rst),
        .gene_we    (gene_we),
        .gene_slot  (gene_slot),
        .gene_src_a (gene_src_a),
        .gene_src_b (gene_src_b),
        .gene_fn    (gene_fn),
        .outsel_we  (outsel_we),
        .outsel_idx (outsel_idx),
        .in_valid   (in_valid),
        .in_win     (in_win),
        .in_ref     (in_ref),
        .err_clr    (err_clr),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .err_sum    (err_sum)
    );

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Bench copy of the genome, written only where the requirements say a write lands.
    int ga[NN];
    int gb[NN];
    int gf[NN];
    int gsel = 0;

    function automatic int model_eval(logic [NI*8-1:0] w);
        int v[NS];
        int a;
        int b;
        for (int i = 0; i < NI; i++) v[i] = int'(w[i*8 +: 8]);
        for (int k = 0; k < NN; k++) begin
            a = (ga[k] < NI + k) ? v[ga[k]] : 0;
            b = (gb[k] < NI + k) ? v[gb[k]] : 0;
            case (gf[k])
                1:       v[NI+k] = (a < b) ? a : b;
                2:       v[NI+k] = (a > b) ? a : b;
                default: v[NI+k] = a;
            endcase
        end
        return (gsel < NS) ? v[gsel] : 0;
    endfunction

    function automatic int sort_median(logic [NI*8-1:0] w);
        int v[NI];
        int t;
        for (int i = 0; i < NI; i++) v[i] = int'(w[i*8 +: 8]);
        for (int i = 0; i < NI; i++)
            for (int j = 0; j < NI - 1 - i; j++)
                if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
        return v[NI/2];
    endfunction

    // Scoreboard
    typedef struct {
        int     s;
        longint acc;
        string  tag;
    } exp_t;

    exp_t   q[$];
    exp_t   cur;
    bit     pv = 1'b0;
    int     ps = 0;
    int     pd = 0;
    string  ptag = "";
    longint macc = 0;

    task automatic model_advance(bit v, int es, int r, bit clr, string tag);
        int d;
        d = pv ? pd : 0;
        if (clr) macc = d;
        else     macc = macc + d;
        if (pv) q.push_back('{ps, macc, ptag});
        pv   = v;
        ps   = es;
        pd   = (es > r) ? es - r : r - es;
        ptag = tag;
    endtask

    task automatic drive(bit v, logic [NI*8-1:0] w, int r, bit clr, string tag, int exp_ovr);
        int es;
        @(posedge clk); #1;
        gene_we   = 1'b0;
        outsel_we = 1'b0;
        in_valid  = v;
        in_win    = w;
        in_ref    = 8'(r);
        err_clr   = clr;
        es = (exp_ovr >= 0) ? exp_ovr : model_eval(w);
        model_advance(v, v ? es : 0, r, clr, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, 0, 1'b0, "", 0);
    endtask

    task automatic write_gene(int slot, int a, int b, int f);
        @(posedge clk); #1;
        in_valid   = 1'b0;
        err_clr    = 1'b0;
        outsel_we  = 1'b0;
        gene_we    = 1'b1;
        gene_slot  = 8'(slot);
        gene_src_a = 8'(a);
        gene_src_b = 8'(b);
        gene_fn    = 2'(f);
        model_advance(1'b0, 0, 0, 1'b0, "");
        if (slot < NN) begin ga[slot] = a; gb[slot] = b; gf[slot] = f; end
    endtask

    task automatic write_sel(int s);
        @(posedge clk); #1;
        in_valid   = 1'b0;
        err_clr    = 1'b0;
        gene_we    = 1'b0;
        outsel_we  = 1'b1;
        outsel_idx = 8'(s);
        model_advance(1'b0, 0, 0, 1'b0, "");
        gsel = s;
    endtask

    function automatic logic [NI*8-1:0] rand_win();
        logic [NI*8-1:0] w;
        for (int i = 0; i < NI; i++) w[i*8 +: 8] = 8'($urandom_range(1, 255));
        return w;
    endfunction

    function automatic logic [NI*8-1:0] mkwin(int b0, int b1, int b2, int b3, int b4,
                                              int b5, int b6, int b7, int b8);
        return {8'(b8), 8'(b7), 8'(b6), 8'(b5), 8'(b4), 8'(b3), 8'(b2), 8'(b1), 8'(b0)};
    endfunction

    // Monitor
    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            if (q.size() == 0) begin
                check(1'b0, "R5", "out_valid with nothing pending", 1, 0);
            end else begin
                cur = q.pop_front();
                check(out_sample == 8'(cur.s), cur.tag, "out_sample", out_sample, cur.s);
                check(err_sum == AW'(cur.acc), "R6", "err_sum", err_sum, cur.acc);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nbad++;
            $display("FAIL R5 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    int lo_i[19] = '{1,4,7,0,3,6,1,4,7,0,5,4,3,1,2,4,4,6,4};
    int hi_i[19] = '{2,5,8,1,4,7,2,5,8,3,8,7,6,4,5,7,2,4,2};

    initial begin
        logic [NI*8-1:0] w;
        int pos[NI];
        int node;
        for (int k = 0; k < NN; k++) begin ga[k] = 0; gb[k] = 0; gf[k] = 0; end

        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(out_sample == 8'd0, "R1", "out_sample after reset", out_sample, 0);
        check(err_sum == '0, "R1", "err_sum after reset", err_sum, 0);

        // R1 default genome forwards sample 0
        w = mkwin(77, 3, 200, 9, 1, 5, 6, 7, 8);
        drive(1'b1, w, 70, 1'b0, "R1", 77);

        // R5 latency: low one negedge after acceptance, high after the next
        drive(1'b0, '0, 0, 1'b0, "", 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R5", "out_valid one edge after accept", out_valid, 0);
        drive(1'b0, '0, 0, 1'b0, "", 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R5", "out_valid two edges after accept", out_valid, 1);
        idle(1);
        @(negedge clk);
        check(out_sample == 8'd77, "R5", "out_sample held while idle", out_sample, 77);
        idle(2);

        // R2 function codes
        write_gene(0, 2, 5, 0);
        write_gene(1, 2, 5, 1);
        write_gene(2, 2, 5, 2);
        write_gene(3, 4, 1, 3);
        for (int s = NI; s < NI + 4; s++) begin
            write_sel(s);
            drive(1'b1, mkwin(1, 2, 30, 4, 50, 90, 7, 8, 9), 10, 1'b0, "R2", -1);
            drive(1'b1, mkwin(1, 2, 90, 4, 60, 30, 7, 8, 9), 10, 1'b0, "R2", -1);
            drive(1'b1, mkwin(1, 2, 44, 4, 5, 44, 7, 8, 9), 10, 1'b0, "R2", -1);
            idle(2);
        end

        // R3 index space and forward references
        write_gene(4, 13, 13, 0);
        write_gene(5, 20, 3, 0);
        write_gene(6, 9, 3, 1);
        write_gene(7, 12, 11, 2);
        write_gene(8, 0, 250, 2);
        for (int s = 13; s < 18; s++) begin
            write_sel(s);
            drive(1'b1, rand_win(), 100, 1'b0, "R3", -1);
            drive(1'b1, rand_win(), 20, 1'b0, "R3", -1);
            idle(2);
        end

        // R4 output select
        write_gene(37, 0, 8, 2);
        write_sel(46);
        drive(1'b1, mkwin(10, 2, 3, 4, 5, 6, 7, 8, 99), 0, 1'b0, "R4", -1);
        idle(2);
        write_sel(4);
        drive(1'b1, mkwin(10, 2, 3, 4, 55, 6, 7, 8, 99), 0, 1'b0, "R4", -1);
        idle(2);
        write_sel(47);
        drive(1'b1, rand_win(), 9, 1'b0, "R4", -1);
        idle(2);
        write_sel(255);
        drive(1'b1, rand_win(), 9, 1'b0, "R4", -1);
        idle(2);

        // R8 out-of-range slots leave node 6 untouched
        write_gene(38, 0, 1, 2);
        write_gene(255, 0, 1, 2);
        write_gene(70, 0, 1, 2);
        write_sel(15);
        drive(1'b1, mkwin(200, 210, 1, 40, 5, 6, 7, 8, 9), 0, 1'b0, "R8", -1);
        idle(2);

        // R7 clear coincident with a landing, then clear on an idle edge
        drive(1'b1, rand_win(), 128, 1'b0, "R7", -1);
        drive(1'b0, '0, 0, 1'b1, "", 0);
        idle(2);
        drive(1'b0, '0, 0, 1'b1, "", 0);
        drive(1'b1, rand_win(), 3, 1'b0, "R7", -1);
        drive(1'b1, rand_win(), 250, 1'b0, "R7", -1);
        idle(3);

        // R9 exact median genome from nineteen exchange pairs
        for (int i = 0; i < NI; i++) pos[i] = i;
        node = 0;
        for (int p = 0; p < 19; p++) begin
            write_gene(node, pos[lo_i[p]], pos[hi_i[p]], 1);
            write_gene(node + 1, pos[lo_i[p]], pos[hi_i[p]], 2);
            pos[lo_i[p]] = NI + node;
            pos[hi_i[p]] = NI + node + 1;
            node += 2;
        end
        write_sel(pos[4]);
        drive(1'b0, '0, 0, 1'b1, "", 0);
        w = mkwin(5, 5, 5, 5, 5, 5, 5, 5, 5);
        drive(1'b1, w, 5, 1'b0, "R9", sort_median(w));
        w = mkwin(9, 8, 7, 6, 5, 4, 3, 2, 1);
        drive(1'b1, w, 6, 1'b0, "R9", sort_median(w));
        w = mkwin(1, 200, 1, 200, 1, 200, 200, 1, 3);
        drive(1'b1, w, 0, 1'b0, "R9", sort_median(w));
        for (int n = 0; n < 300; n++) begin
            w = rand_win();
            drive(1'b1, w, $urandom_range(0, 255), ($urandom_range(0, 15) == 0),
                  "R9", sort_median(w));
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(3);

        // R2 R3 random reduced genomes against the bench evaluator, R6 R7 under traffic
        for (int g = 0; g < 4; g++) begin
            for (int k = 0; k < NN; k++) begin
                write_gene(k, $urandom_range(0, NI + k), $urandom_range(0, NI + k),
                           $urandom_range(0, 3));
            end
            write_sel($urandom_range(NI + 6, NI + 34));
            for (int n = 0; n < 120; n++) begin
                drive(1'b1, rand_win(), $urandom_range(0, 255),
                      ($urandom_range(0, 20) == 0), "R2 R3", -1);
                if ($urandom_range(0, 4) == 0) idle(1);
            end
            idle(3);
        end

        idle(3);
        @(negedge clk);
        check(q.size() == 0, "R5", "results still pending", q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule